// File: doc/BRIEF.md
# Cascaded DMA Request Mask Unit

This unit keeps one mask bit for each of eight DMA request channels and uses those bits to gate the incoming request lines. The channels form two groups of four. The lower group (channels 0 to 3) reaches the bus only through channel 4 of the upper group. For that reason, a set mask bit on channel 4 also silences all four lower channels.

Software reaches each group through a byte-wide register.

- **Group-wide access.** A write to the group's address loads all four mask bits of that group at once. A read at the same address returns the four bits, with the upper nibble always zero.
- **Single-channel access.** A separate port sets or clears one chosen bit.

Hardware can also change the mask bits:

- A master-clear strobe for a group masks that whole group.
- A terminal-count pulse masks its own channel, unless that channel runs in auto-initialization mode.

The request inputs are asynchronous, so they pass through a synchronizer before the gate. After that, the gated outputs follow the registered mask combinationally.

Top module: `dma_req_mask`

## Requirements
- R1: After reset all eight mask bits are 1 (`mask_q` = FFh), and each group's register reads 0Fh.
- R2: A write with `io_addr` = 0Fh loads `mask_q[3:0]` from `io_wdata[3:0]`. A write with `io_addr` = DEh loads `mask_q[7:4]` from `io_wdata[3:0]`. A write to any other address changes no mask bit.
- R3: `mclr[0]` sets `mask_q[3:0]` to 1111b and `mclr[1]` sets `mask_q[7:4]` to 1111b, in the cycle after the strobe.
- R4: For an upper channel n (4 to 7), `dreq_gated[n]` is the synchronized `dreq[n]` AND NOT `mask_q[n]`.
- R5: For a lower channel n (0 to 3), `dreq_gated[n]` is the synchronized `dreq[n]` AND NOT `mask_q[n]` AND NOT `mask_q[4]`.
- R6: A pulse on `tc[n]` sets `mask_q[n]` to 1 when `autoinit[n]` is 0, and leaves the bit unchanged when `autoinit[n]` is 1.
- R7: A single-channel write (`sm_wr`) sets channel `sm_grp`*4 + `sm_sel` to `sm_set`, where `sm_grp` 0 is the lower group and 1 the upper group. All other bits stay unchanged.
- R8: When several updates hit the same bit in one cycle, master clear wins. Below it, terminal count beats the group-wide write, and the group-wide write beats the single-channel write.
- R9: `io_rdata` shows {0000b, `mask_q[3:0]`} when `io_addr` = 0Fh and {0000b, `mask_q[7:4]`} when `io_addr` = DEh. At any other address it shows 00h. Bits 7:4 always read 0, whatever was written to them.
- R10: A change on `dreq` reaches `dreq_gated` after SYNC_STAGES (default 2) rising edges. A mask update shows on `mask_q` and `dreq_gated` right after the edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Register write strobe |
| io_addr | input | 8 | Register address (0Fh lower group, DEh upper group) |
| io_wdata | input | 8 | Write data; bits 3:0 are the mask bits |
| io_rdata | output | 8 | Read data for the addressed group |
| sm_wr | input | 1 | Single-channel mask write strobe |
| sm_grp | input | 1 | Group for the single write (0 lower, 1 upper) |
| sm_sel | input | 2 | Channel within the group |
| sm_set | input | 1 | New value for the selected mask bit |
| mclr | input | 2 | Master clear per group (bit 0 lower, bit 1 upper) |
| tc | input | 8 | Terminal-count pulse per channel |
| autoinit | input | 8 | Auto-initialization mode flag per channel |
| dreq | input | 8 | Asynchronous request lines |
| dreq_gated | output | 8 | Masked, synchronized request lines |
| mask_q | output | 8 | Current mask bits, bit n for channel n |

## Verification
The bench masks channel 4 while the lower channels stay unmasked. A design that ignored the cascade would keep passing the lower-group requests. It pulses terminal count on a channel in auto-initialization mode; a design that ignored the mode flag would wrongly mask that channel.

It also drives updates that collide on one bit:

- a group-wide write with terminal count;
- master clear with a write;
- a group-wide write with a single-channel write.

A wrong priority order leaves a bit at the losing value.

Finally, it writes ones into the reserved nibble and to an unmapped address. A design that stored those bits, or that decoded the address loosely, shows the difference on the read data.

// File: rtl/dma_req_mask.sv
module dma_req_mask #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] LO_ADDR     = 8'h0F,
  parameter logic [7:0] HI_ADDR     = 8'hDE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_wr,
  input  logic [7:0] io_addr,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  input  logic       sm_wr,
  input  logic       sm_grp,
  input  logic [1:0] sm_sel,
  input  logic       sm_set,
  input  logic [1:0] mclr,
  input  logic [7:0] tc,
  input  logic [7:0] autoinit,
  input  logic [7:0] dreq,
  output logic [7:0] dreq_gated,
  output logic [7:0] mask_q
);
  localparam int NGRP = 2;
  localparam int GCH  = 4;
  localparam int NCH  = NGRP * GCH;

  logic [NCH-1:0] sync_q [SYNC_STAGES];
  logic [NCH-1:0] mask_d;
  logic [NGRP-1:0] wr_grp;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= dreq;

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sync_q[s] <= '0;
      else        sync_q[s] <= sync_q[s-1];
  end

  assign wr_grp = {io_wr && (io_addr == HI_ADDR), io_wr && (io_addr == LO_ADDR)};

  always_comb begin
    mask_d = mask_q;
    for (int g = 0; g < NGRP; g++) begin
      for (int b = 0; b < GCH; b++) begin
        if (sm_wr && sm_grp == 1'(g) && sm_sel == 2'(b)) mask_d[g*GCH+b] = sm_set;
        if (wr_grp[g])                                   mask_d[g*GCH+b] = io_wdata[b];
        if (tc[g*GCH+b] && !autoinit[g*GCH+b])           mask_d[g*GCH+b] = 1'b1;
        if (mclr[g])                                     mask_d[g*GCH+b] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_d;

  assign dreq_gated = sync_q[SYNC_STAGES-1] & ~mask_q & {{GCH{1'b1}}, {GCH{~mask_q[GCH]}}};

  assign io_rdata = (io_addr == LO_ADDR) ? {4'b0, mask_q[GCH-1:0]} :
                    (io_addr == HI_ADDR) ? {4'b0, mask_q[NCH-1:GCH]} : 8'h00;
endmodule

// File: rtl/dma_req_mask_chk.sv
module dma_req_mask_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       io_wr,
  input logic [7:0] io_addr,
  input logic [7:0] io_wdata,
  input logic [7:0] io_rdata,
  input logic       sm_wr,
  input logic       sm_grp,
  input logic [1:0] sm_sel,
  input logic       sm_set,
  input logic [1:0] mclr,
  input logic [7:0] tc,
  input logic [7:0] autoinit,
  input logic [7:0] dreq,
  input logic [7:0] dreq_gated,
  input logic [7:0] mask_q
);
  AST_RESET_MASKED: assert property (@(posedge clk) !rst_n |=> mask_q == 8'hFF); // R1
  AST_MCLR_LO: assert property (@(posedge clk) disable iff (!rst_n) mclr[0] |=> mask_q[3:0] == 4'hF); // R3
  AST_MCLR_HI: assert property (@(posedge clk) disable iff (!rst_n) mclr[1] |=> mask_q[7:4] == 4'hF); // R3
  AST_TC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (tc & ~autoinit) != 8'h00 |=> (mask_q & $past(tc & ~autoinit)) == $past(tc & ~autoinit)); // R6
  AST_UPPER_GATE: assert property (@(posedge clk) disable iff (!rst_n) (dreq_gated[7:4] & mask_q[7:4]) == 4'h0); // R4
  AST_CASCADE: assert property (@(posedge clk) disable iff (!rst_n) mask_q[4] |-> dreq_gated[3:0] == 4'h0); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) io_rdata[7:4] == 4'h0); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_wr && !sm_wr && mclr == 2'b00 && (tc & ~autoinit) == 8'h00) |=> $stable(mask_q)); // R2
endmodule

bind dma_req_mask dma_req_mask_chk chk (.*);

// File: tb/dma_req_mask_test.sv
module dma_req_mask_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_wr = 1'b0;
  logic [7:0] io_addr = 8'h00;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic       sm_wr = 1'b0;
  logic       sm_grp = 1'b0;
  logic [1:0] sm_sel = 2'b00;
  logic       sm_set = 1'b0;
  logic [1:0] mclr = 2'b00;
  logic [7:0] tc = 8'h00;
  logic [7:0] autoinit = 8'h00;
  logic [7:0] dreq = 8'h00;
  logic [7:0] dreq_gated;
  logic [7:0] mask_q;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  dma_req_mask uut (.*);

  task automatic push(int kind, logic [7:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk); #2;
    io_wr = 0; sm_wr = 0; mclr = 0; tc = 0;
  endtask

  task automatic setup();
    @(negedge clk); #1;
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = (it.kind == 0) ? mask_q : (it.kind == 1) ? dreq_gated : io_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind %0d actual %02h expected %02h", it.req, it.kind, act, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual %0d expected <5000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    setup(); rst_n = 1; io_addr = 8'h0F;
    push(0, 8'hFF, "R1"); push(2, 8'h0F, "R1");
    setup(); io_addr = 8'hDE;
    push(2, 8'h0F, "R1 R9");

    setup(); io_wr = 1; io_addr = 8'h0F; io_wdata = 8'hF0; tick();
    push(0, 8'hF0, "R2"); push(2, 8'h00, "R9 R10");
    setup(); io_wr = 1; io_addr = 8'hDE; io_wdata = 8'h0A; tick();
    push(0, 8'hA0, "R2"); push(2, 8'h0A, "R9");
    setup(); io_wr = 1; io_addr = 8'h10; io_wdata = 8'h0F; tick();
    push(0, 8'hA0, "R2"); push(2, 8'h00, "R9");

    setup(); dreq = 8'hFF; tick();
    push(1, 8'h00, "R10");
    setup(); tick();
    push(1, 8'h5F, "R4 R10");

    setup(); sm_wr = 1; sm_grp = 1; sm_sel = 0; sm_set = 1; tick();
    push(0, 8'hB0, "R7"); push(1, 8'h40, "R5");
    setup(); sm_wr = 1; sm_grp = 1; sm_sel = 0; sm_set = 0; tick();
    push(0, 8'hA0, "R7"); push(1, 8'h5F, "R5");
    setup(); sm_wr = 1; sm_grp = 0; sm_sel = 3; sm_set = 1; tick();
    push(0, 8'hA8, "R7"); push(1, 8'h57, "R4");
    setup(); sm_wr = 1; sm_grp = 0; sm_sel = 3; sm_set = 0; tick();
    push(0, 8'hA0, "R7");

    setup(); tc = 8'h02; tick();
    push(0, 8'hA2, "R6"); push(1, 8'h5D, "R6");
    setup(); tc = 8'h04; autoinit = 8'h04; tick();
    push(0, 8'hA2, "R6");
    setup(); autoinit = 8'h00;

    setup(); io_wr = 1; io_addr = 8'h0F; io_wdata = 8'h00; tc = 8'h01; tick();
    push(0, 8'hA1, "R8");
    setup(); io_wr = 1; io_addr = 8'h0F; io_wdata = 8'h00; mclr = 2'b01; tick();
    push(0, 8'hAF, "R3 R8"); push(1, 8'h50, "R3");
    setup(); mclr = 2'b10; tick();
    push(0, 8'hFF, "R3"); push(1, 8'h00, "R5");
    setup(); io_wr = 1; io_addr = 8'hDE; io_wdata = 8'h00; sm_wr = 1; sm_grp = 1; sm_sel = 1; sm_set = 1; tick();
    push(0, 8'h0F, "R8");
    setup(); io_addr = 8'h55;
    push(2, 8'h00, "R9");

    setup(); setup();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule